// File: doc/BRIEF.md
# Multi-Page Write Cache Controller

This block sits between the byte stream of a serial write command and the program port of a non-volatile memory array. A command opens with a start address. The data bytes that follow are collected in a 64-byte cache of eight lines, each eight bytes wide. Line N always stands for the array page N places after the page that holds the start address. The cache is not flushed while bytes arrive. When the bus signals the end of the command, the controller walks the lines in ascending order and issues one page-program request for each line that received data. After each request it waits a fixed number of cycles that model the self-timed program pulse.

The array is addressed as 128 rows of 8 pages, each page 8 bytes. The page address `cmd_addr[12:3]` therefore splits into a row field `[12:6]` and a page-within-row field `[5:3]`. A flush that starts partway through a row continues into the next row. A flush that starts near the top of the array wraps to row 0. A 16-bit mask can protect any 512-byte block. Lines that fall in a protected block are dropped silently, with no error.

Top module: `wcache_ctrl`

## Requirements
- R1: After a synchronous reset, `busy` and `prog_valid` are 0 and no command is open.
- R2: A `cmd_start` accepted while not busy opens a command. Bytes on `wr_valid` fill cache line 0 from byte `cmd_addr[2:0]` upward and then the following lines in order, so a page-aligned start puts the first byte in line 0, byte 0.
- R3: Line i is programmed at page address `P = cmd_addr[12:3] + i` modulo 1024, reported as `prog_row = P[9:3]` and `prog_page = P[2:0]`. This lets a flush run across a row boundary and wrap past the top of the array.
- R4: No program request is made before `stop`. A `stop` sampled while a command is open raises `busy` on the next cycle. `busy` stays high until the wait after the last line has ended.
- R5: The flush visits lines 0 to 7 in ascending order. A line with at least one written byte gets one single-cycle `prog_valid` pulse, followed by `PROG_CYCLES` cycles of waiting. A line with no written byte takes one cycle and makes no request.
- R6: For each request, `prog_be[b]` is 1 exactly when byte b of that line was written during the command. `prog_data[8b+7:8b]` then holds the last value written there, and reads 0 where `prog_be[b]` is 0.
- R7: After byte 63 of the cache, the write position wraps to line 0, byte 0, so only the last 64 bytes of a long command remain.
- R8: `prot_mask[k]` protects every page whose address bits `[9:6]` equal k. A line that maps into a protected block is passed over like an empty line, with no request and no error.
- R9: While `busy`, the inputs `cmd_start`, `wr_valid` and `stop` have no effect. Bytes and `stop` that arrive with no open command are also ignored. A flush closes the command.
- R10: A `cmd_start` while a command is open, but not yet flushing, restarts it and discards every byte cached so far.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | Opens or restarts a write command |
| cmd_addr | input | 13 | Byte address of the first data byte |
| wr_valid | input | 1 | Data byte strobe |
| wr_data | input | 8 | Data byte |
| stop | input | 1 | End-of-command event that starts the flush |
| prot_mask | input | 16 | One protect bit per 512-byte block |
| busy | output | 1 | Flush in progress |
| prog_valid | output | 1 | Page-program request, one cycle |
| prog_row | output | 7 | Row of the page to program |
| prog_page | output | 3 | Page within the row |
| prog_data | output | 64 | Page data, byte b at bits 8b+7:8b |
| prog_be | output | 8 | Per-byte program enables |

## Verification
The bench aims at the corner cases of the address arithmetic:
- A start at a mid-page offset. A design that ignored the offset would shift every byte and enable the wrong lanes.
- A full cache that begins at page 3. If the row is not carried, the last three lines land back in pages 0 to 2 of the first row.
- A start at page 1022. If the page address does not wrap, the requests go to pages that do not exist.

It also covers the following cases:
- A command longer than the cache. Here a missing pointer wrap would drop the newest bytes.
- A flush that straddles a protected block boundary. A faulty design would program protected pages or stall on them.
- A restart before `stop`. Stale bytes that were not cleared would appear as extra enables.
- Traffic while busy. A design that accepted it would corrupt lines that have not yet been programmed.

// File: rtl/wc_pkg.sv
// Shared definitions for the write cache controller.
// Holds the flush sequencer state type and the byte width used by every stage.
package wc_pkg;
    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        FS_IDLE = 2'd0,   // no command open
        FS_OPEN = 2'd1,   // collecting bytes
        FS_SCAN = 2'd2,   // deciding on the current line
        FS_PROG = 2'd3    // waiting out a program pulse
    } fs_state_t;
endpackage

// File: rtl/wc_cache_store.sv
// Cache byte storage with per-byte written flags and a wrapping write pointer.
// Assumes LINES and LINE_BYTES are powers of two, so the pointer wraps by overflow.
// One line at a time is read out, with unwritten bytes forced to zero.
module wc_cache_store #(
    parameter int LINES      = 8,
    parameter int LINE_BYTES = 8,
    parameter int LINE_W     = $clog2(LINES),
    parameter int OFF_W      = $clog2(LINE_BYTES),
    parameter int PTR_W      = LINE_W + OFF_W
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                clear,
    input  logic [OFF_W-1:0]                    start_off,
    input  logic                                wr_en,
    input  logic [wc_pkg::BYTE_W-1:0]           wr_data,
    input  logic [LINE_W-1:0]                   rd_line,
    output logic [LINE_BYTES*wc_pkg::BYTE_W-1:0] rd_data,
    output logic [LINE_BYTES-1:0]               rd_fill
);
    import wc_pkg::*;

    localparam int TOTAL = LINES * LINE_BYTES;

    logic [BYTE_W-1:0] mem [TOTAL];
    logic [TOTAL-1:0]  fill_q;
    logic [PTR_W-1:0]  ptr_q;

    // Store each accepted byte at the current pointer.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[ptr_q] <= wr_data;
        end
    end

    // Track written bytes and advance the pointer; a new command clears both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fill_q <= '0;
            ptr_q  <= '0;
        end else if (clear) begin
            fill_q <= '0;
            ptr_q  <= {{LINE_W{1'b0}}, start_off};
        end else if (wr_en) begin
            fill_q[ptr_q] <= 1'b1;
            ptr_q         <= ptr_q + PTR_W'(1);
        end
    end

    // Present the selected line, masking bytes that were never written.
    for (genvar b = 0; b < LINE_BYTES; b++) begin : g_byte
        logic [PTR_W-1:0] idx;
        assign idx = {rd_line, OFF_W'(b)};
        assign rd_fill[b] = fill_q[idx];
        assign rd_data[b*BYTE_W +: BYTE_W] = fill_q[idx] ? mem[idx] : '0;
    end

    // R10: starting a command leaves no byte marked as written.
    a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (fill_q == '0))
        else $error("cache not emptied by command start");

    // R7: the pointer wraps from the last cache byte back to line 0, byte 0.
    a_r7_ptr_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clear && (ptr_q == '1)) |=> (ptr_q == '0))
        else $error("write pointer did not wrap");
endmodule

// File: rtl/wc_prot_check.sv
// Looks up the protect bit of the block that holds a page address.
// Assumes BLOCK_PAGES is a power of two that divides the page space evenly.
module wc_prot_check #(
    parameter int PAGE_W      = 10,
    parameter int BLOCK_PAGES = 64,
    parameter int BLK_SH      = $clog2(BLOCK_PAGES),
    parameter int BLOCKS      = (1 << PAGE_W) / BLOCK_PAGES
) (
    input  logic [PAGE_W-1:0] page_addr,
    input  logic [BLOCKS-1:0] mask,
    output logic              is_protected
);
    logic [PAGE_W-BLK_SH-1:0] blk;

    // Select the block index and return its mask bit.
    always_comb begin
        blk          = page_addr[PAGE_W-1:BLK_SH];
        is_protected = mask[blk];
    end
endmodule

// File: rtl/wc_flush_seq.sv
// Command and flush sequencer.
// Opens a command on start, begins the flush on stop, and visits each cache line once.
// For an eligible line it fires a single program request, then waits PROG_CYCLES cycles.
// Assumes PROG_CYCLES >= 1.
module wc_flush_seq #(
    parameter int LINES       = 8,
    parameter int PROG_CYCLES = 12,
    parameter int LINE_W      = $clog2(LINES),
    parameter int CNT_W       = $clog2(PROG_CYCLES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic              stop,
    input  logic              line_eligible,
    output logic              busy,
    output logic              cmd_open,
    output logic              prog_fire,
    output logic [LINE_W-1:0] line_idx
);
    import wc_pkg::*;

    localparam logic [LINE_W-1:0] LAST_LINE = LINE_W'(LINES - 1);
    localparam logic [CNT_W-1:0]  CNT_LOAD  = CNT_W'(PROG_CYCLES - 1);

    fs_state_t         state_q;
    logic [LINE_W-1:0] line_q;
    logic [CNT_W-1:0]  cnt_q;

    // Step the command and flush state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_IDLE;
            line_q  <= '0;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                FS_IDLE: begin
                    if (cmd_start) state_q <= FS_OPEN;
                end
                FS_OPEN: begin
                    if (!cmd_start && stop) begin
                        state_q <= FS_SCAN;
                        line_q  <= '0;
                    end
                end
                FS_SCAN: begin
                    if (line_eligible) begin
                        state_q <= FS_PROG;
                        cnt_q   <= CNT_LOAD;
                    end else if (line_q == LAST_LINE) begin
                        state_q <= FS_IDLE;
                    end else begin
                        line_q <= line_q + LINE_W'(1);
                    end
                end
                FS_PROG: begin
                    if (cnt_q != '0) begin
                        cnt_q <= cnt_q - CNT_W'(1);
                    end else if (line_q == LAST_LINE) begin
                        state_q <= FS_IDLE;
                    end else begin
                        line_q  <= line_q + LINE_W'(1);
                        state_q <= FS_SCAN;
                    end
                end
                default: state_q <= FS_IDLE;
            endcase
        end
    end

    // Decode the externally visible status from the state.
    always_comb begin
        busy      = (state_q == FS_SCAN) || (state_q == FS_PROG);
        cmd_open  = (state_q == FS_OPEN);
        prog_fire = (state_q == FS_SCAN) && line_eligible;
        line_idx  = line_q;
    end

    // R4: a flush only begins in the cycle after a stop.
    a_r4_rise_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop))
        else $error("busy rose without stop");

    // R5: each program request lasts exactly one cycle.
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        prog_fire |=> !prog_fire)
        else $error("program request longer than one cycle");

    // R9: a finished flush leaves no command open.
    a_r9_closed_after_flush: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> !cmd_open)
        else $error("command still open after flush");
endmodule

// File: rtl/wcache_ctrl.sv
// Multi-page write cache controller, top level.
// Captures the start page, routes bytes into the cache while a command is open,
// and on stop drives page-program requests line by line.
// Lines that are empty or fall in a protected block are skipped.
// Assumes a power-of-two geometry with rows of ROW_PAGES pages.
module wcache_ctrl #(
    parameter int ADDR_W      = 13,
    parameter int LINE_BYTES  = 8,
    parameter int LINES       = 8,
    parameter int ROW_PAGES   = 8,
    parameter int BLOCK_PAGES = 64,
    parameter int PROG_CYCLES = 12,
    parameter int OFF_W       = $clog2(LINE_BYTES),
    parameter int LINE_W      = $clog2(LINES),
    parameter int PAGE_W      = ADDR_W - OFF_W,
    parameter int ROWP_W      = $clog2(ROW_PAGES),
    parameter int ROW_W       = PAGE_W - ROWP_W,
    parameter int BLOCKS      = (1 << PAGE_W) / BLOCK_PAGES
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_start,
    input  logic [ADDR_W-1:0]         cmd_addr,
    input  logic                      wr_valid,
    input  logic [7:0]                wr_data,
    input  logic                      stop,
    input  logic [BLOCKS-1:0]         prot_mask,
    output logic                      busy,
    output logic                      prog_valid,
    output logic [ROW_W-1:0]          prog_row,
    output logic [ROWP_W-1:0]         prog_page,
    output logic [LINE_BYTES*8-1:0]   prog_data,
    output logic [LINE_BYTES-1:0]     prog_be
);
    localparam int BLK_SH = $clog2(BLOCK_PAGES);

    logic [PAGE_W-1:0]       start_page_q;
    logic                    accept_start;
    logic                    wr_en;
    logic                    cmd_open;
    logic                    prog_fire;
    logic [LINE_W-1:0]       line_idx;
    logic [PAGE_W-1:0]       cur_page;
    logic [LINE_BYTES*8-1:0] line_data;
    logic [LINE_BYTES-1:0]   line_fill;
    logic                    line_prot;
    logic                    line_eligible;
    logic [PAGE_W-1:0]       out_page;

    // Qualify incoming command events against the sequencer state.
    always_comb begin
        accept_start = cmd_start && !busy;
        wr_en        = wr_valid && cmd_open && !cmd_start && !stop;
    end

    // Latch the page that cache line 0 stands for.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_page_q <= '0;
        end else if (accept_start) begin
            start_page_q <= cmd_addr[ADDR_W-1:OFF_W];
        end
    end

    wc_cache_store #(
        .LINES      (LINES),
        .LINE_BYTES (LINE_BYTES)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (accept_start),
        .start_off (cmd_addr[OFF_W-1:0]),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_line   (line_idx),
        .rd_data   (line_data),
        .rd_fill   (line_fill)
    );

    wc_prot_check #(
        .PAGE_W      (PAGE_W),
        .BLOCK_PAGES (BLOCK_PAGES)
    ) u_prot (
        .page_addr    (cur_page),
        .mask         (prot_mask),
        .is_protected (line_prot)
    );

    wc_flush_seq #(
        .LINES       (LINES),
        .PROG_CYCLES (PROG_CYCLES)
    ) u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_start     (cmd_start),
        .stop          (stop),
        .line_eligible (line_eligible),
        .busy          (busy),
        .cmd_open      (cmd_open),
        .prog_fire     (prog_fire),
        .line_idx      (line_idx)
    );

    // Map the current line onto the array and decide whether it is programmed.
    always_comb begin
        cur_page      = start_page_q + PAGE_W'(line_idx);
        line_eligible = (|line_fill) && !line_prot;
    end

    // Drive the program request port.
    always_comb begin
        prog_valid = prog_fire;
        prog_row   = cur_page[PAGE_W-1:ROWP_W];
        prog_page  = cur_page[ROWP_W-1:0];
        prog_data  = line_data;
        prog_be    = line_fill;
        out_page   = {prog_row, prog_page};
    end

    // R8: no request ever targets a page in a protected block.
    a_r8_prot_never_programmed: assert property (@(posedge clk) disable iff (!rst_n)
        prog_valid |-> !prot_mask[out_page[PAGE_W-1:BLK_SH]])
        else $error("request into protected block");

    // R6: every request enables at least one byte.
    a_r6_be_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        prog_valid |-> (prog_be != '0))
        else $error("request with no byte enabled");

    // R4: requests only appear during a flush.
    a_r4_prog_in_flush: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_valid) |-> ($past(busy) || $past(stop)))
        else $error("request outside a flush");
endmodule

// File: tb/wcache_ctrl_bench.sv
// Bench for wcache_ctrl: a behavioural queue-based model is compared every clock.
module wcache_ctrl_bench;
    localparam int P = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [12:0] cmd_addr = '0;
    logic        wr_valid = 1'b0;
    logic [7:0]  wr_data = '0;
    logic        stop = 1'b0;
    logic [15:0] prot_mask = '0;
    logic        busy;
    logic        prog_valid;
    logic [6:0]  prog_row;
    logic [2:0]  prog_page;
    logic [63:0] prog_data;
    logic [7:0]  prog_be;

    always #5 clk = ~clk;

    wcache_ctrl #(.PROG_CYCLES(P)) u_wcache_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_addr(cmd_addr),
        .wr_valid(wr_valid), .wr_data(wr_data), .stop(stop), .prot_mask(prot_mask),
        .busy(busy), .prog_valid(prog_valid), .prog_row(prog_row), .prog_page(prog_page),
        .prog_data(prog_data), .prog_be(prog_be)
    );

    typedef struct {
        bit          v;
        int          row;
        int          page;
        logic [63:0] data;
        logic [7:0]  be;
    } ev_t;

    ev_t  exp_q[$];
    ev_t  obs_q[$];
    int   checks = 0;
    int   errors = 0;
    logic [7:0] m_cache [64];
    bit   m_fill [64];
    int   m_ptr = 0;
    int   m_sp = 0;
    bit   m_open = 0;

    task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // Reference model: advances on each rising edge from the same inputs.
    ev_t mev;
    int  mpg;
    bit  mbusy;
    always @(posedge clk) begin
        if (!rst_n) begin
            exp_q.delete();
            m_open = 0;
        end else begin
            mbusy = exp_q.size() > 0;
            if (mbusy) begin
                void'(exp_q.pop_front());
            end else if (cmd_start) begin
                m_open = 1;
                m_sp   = int'(cmd_addr) / 8;
                m_ptr  = int'(cmd_addr) % 8;
                for (int i = 0; i < 64; i++) m_fill[i] = 0;
            end else if (stop && m_open) begin
                m_open = 0;
                for (int ln = 0; ln < 8; ln++) begin
                    mpg = (m_sp + ln) % 1024;
                    mev.v = 0; mev.row = 0; mev.page = 0; mev.data = '0; mev.be = '0;
                    for (int b = 0; b < 8; b++) begin
                        if (m_fill[ln*8+b]) begin
                            mev.be[b] = 1'b1;
                            mev.data[b*8 +: 8] = m_cache[ln*8+b];
                        end
                    end
                    if (mev.be != 0 && !prot_mask[mpg/64]) begin
                        mev.v = 1; mev.row = mpg / 8; mev.page = mpg % 8;
                        exp_q.push_back(mev);
                        mev.v = 0;
                        for (int k = 0; k < P; k++) exp_q.push_back(mev);
                    end else begin
                        mev.v = 0;
                        exp_q.push_back(mev);
                    end
                end
            end else if (wr_valid && m_open) begin
                m_cache[m_ptr] = wr_data;
                m_fill[m_ptr]  = 1;
                m_ptr = (m_ptr + 1) % 64;
            end
        end
    end

    // Compare the design against the model midway through every cycle.
    ev_t cf;
    bit  cbusy;
    ev_t oe;
    always @(negedge clk) begin
        if (rst_n) begin
            cbusy = exp_q.size() > 0;
            cf.v = 0;
            if (cbusy) cf = exp_q[0];
            chk("R4", "busy", 64'(busy), 64'(cbusy));
            chk("R5", "prog_valid", 64'(prog_valid), 64'(cf.v));
            if (cf.v && prog_valid) begin
                chk("R3", "prog_row", 64'(prog_row), 64'(cf.row));
                chk("R3", "prog_page", 64'(prog_page), 64'(cf.page));
                chk("R6", "prog_be", 64'(prog_be), 64'(cf.be));
                chk("R6", "prog_data", prog_data, cf.data);
            end
            if (prog_valid) begin
                oe.v = 1; oe.row = int'(prog_row); oe.page = int'(prog_page);
                oe.data = prog_data; oe.be = prog_be;
                obs_q.push_back(oe);
            end
        end
    end

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic send(input logic [7:0] b);
        wr_data = b; wr_valid = 1'b1;
        step();
        wr_valid = 1'b0;
    endtask

    task automatic open_cmd(input int addr);
        cmd_addr = 13'(addr); cmd_start = 1'b1;
        step();
        cmd_start = 1'b0;
    endtask

    task automatic end_cmd();
        stop = 1'b1;
        step();
        stop = 1'b0;
    endtask

    task automatic wait_idle();
        int guard = 0;
        while (busy && guard < 2000) begin
            step();
            guard++;
        end
        step();
    endtask

    initial begin
        #1_000_000;
        errors++;
        $display("FAIL R4 watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1", "busy after reset", 64'(busy), 64'd0);
        chk("R1", "prog_valid after reset", 64'(prog_valid), 64'd0);

        // R2: aligned start at row 1, page 0
        obs_q.delete();
        open_cmd(13'h0040);
        send(8'hA0); send(8'hA1); send(8'hA2);
        end_cmd(); wait_idle();
        chk("R2", "request count", 64'(obs_q.size()), 64'd1);
        if (obs_q.size() > 0) begin
            chk("R2", "row", 64'(obs_q[0].row), 64'd1);
            chk("R2", "page", 64'(obs_q[0].page), 64'd0);
            chk("R2", "be", 64'(obs_q[0].be), 64'h07);
            chk("R2", "first byte", 64'(obs_q[0].data[7:0]), 64'hA0);
        end

        // R6: start at row 3, page 2, offset 5
        obs_q.delete();
        open_cmd(213);
        for (int i = 0; i < 6; i++) send(8'(8'h10 + i));
        end_cmd(); wait_idle();
        chk("R6", "request count", 64'(obs_q.size()), 64'd2);
        if (obs_q.size() > 1) begin
            chk("R6", "line0 be", 64'(obs_q[0].be), 64'hE0);
            chk("R6", "line0 byte5", 64'(obs_q[0].data[47:40]), 64'h10);
            chk("R6", "line0 low bytes zero", 64'(obs_q[0].data[39:0]), 64'h0);
            chk("R6", "line1 page", 64'(obs_q[1].page), 64'd3);
            chk("R6", "line1 be", 64'(obs_q[1].be), 64'h07);
            chk("R6", "line1 byte2", 64'(obs_q[1].data[23:16]), 64'h15);
        end

        // R3: full cache from row 2, page 3 spills into row 3
        obs_q.delete();
        open_cmd(152);
        for (int i = 0; i < 64; i++) send(8'(i * 3));
        end_cmd(); wait_idle();
        chk("R3", "request count", 64'(obs_q.size()), 64'd8);
        if (obs_q.size() == 8) begin
            chk("R3", "line4 row", 64'(obs_q[4].row), 64'd2);
            chk("R3", "line4 page", 64'(obs_q[4].page), 64'd7);
            chk("R3", "line5 row", 64'(obs_q[5].row), 64'd3);
            chk("R3", "line5 page", 64'(obs_q[5].page), 64'd0);
            chk("R3", "line7 page", 64'(obs_q[7].page), 64'd2);
        end

        // R7: 70 bytes wrap over line 0
        obs_q.delete();
        open_cmd(0);
        for (int i = 0; i < 70; i++) send(8'(i));
        end_cmd(); wait_idle();
        chk("R7", "request count", 64'(obs_q.size()), 64'd8);
        if (obs_q.size() > 0) begin
            chk("R7", "byte0 overwritten", 64'(obs_q[0].data[7:0]), 64'd64);
            chk("R7", "byte5 overwritten", 64'(obs_q[0].data[47:40]), 64'd69);
            chk("R7", "byte6 kept", 64'(obs_q[0].data[55:48]), 64'd6);
            chk("R7", "be full", 64'(obs_q[0].be), 64'hFF);
        end

        // R8: block 1 protected, flush straddles its lower edge
        prot_mask = 16'h0002;
        obs_q.delete();
        open_cmd(496);
        for (int i = 0; i < 32; i++) send(8'(8'h80 + i));
        end_cmd(); wait_idle();
        chk("R8", "request count", 64'(obs_q.size()), 64'd2);
        if (obs_q.size() == 2) begin
            chk("R8", "last page before block", 64'(obs_q[1].page), 64'd7);
            chk("R8", "row", 64'(obs_q[1].row), 64'd7);
        end
        prot_mask = 16'h0000;

        // R3: wrap past the top of the array
        obs_q.delete();
        open_cmd(8176);
        for (int i = 0; i < 24; i++) send(8'(i));
        end_cmd(); wait_idle();
        chk("R3", "wrap count", 64'(obs_q.size()), 64'd3);
        if (obs_q.size() == 3) begin
            chk("R3", "top row", 64'(obs_q[1].row), 64'd127);
            chk("R3", "wrapped row", 64'(obs_q[2].row), 64'd0);
            chk("R3", "wrapped page", 64'(obs_q[2].page), 64'd0);
        end

        // R9: traffic during the flush and a stray stop afterwards
        obs_q.delete();
        open_cmd(13'h0100);
        for (int i = 0; i < 16; i++) send(8'(8'h30 + i));
        end_cmd();
        for (int i = 0; i < 5; i++) send(8'hEE);
        open_cmd(0);
        end_cmd();
        wait_idle();
        chk("R9", "request count", 64'(obs_q.size()), 64'd2);
        if (obs_q.size() == 2) begin
            chk("R9", "line1 byte0", 64'(obs_q[1].data[7:0]), 64'h38);
            chk("R9", "line1 byte7", 64'(obs_q[1].data[63:56]), 64'h3F);
        end
        send(8'h77);
        end_cmd();
        step();
        chk("R9", "stray stop busy", 64'(busy), 64'd0);

        // R10: restart discards the earlier bytes
        obs_q.delete();
        open_cmd(0);
        for (int i = 0; i < 8; i++) send(8'hC0);
        open_cmd(13'h0200);
        send(8'h55); send(8'h66);
        end_cmd(); wait_idle();
        chk("R10", "request count", 64'(obs_q.size()), 64'd1);
        if (obs_q.size() == 1) begin
            chk("R10", "row", 64'(obs_q[0].row), 64'd8);
            chk("R10", "be", 64'(obs_q[0].be), 64'h03);
            chk("R10", "data", 64'(obs_q[0].data[15:0]), 64'h6655);
        end

        // R4: nothing is programmed until stop
        obs_q.delete();
        open_cmd(13'h0080);
        for (int i = 0; i < 4; i++) send(8'(8'h90 + i));
        repeat (20) step();
        chk("R4", "busy before stop", 64'(busy), 64'd0);
        chk("R4", "requests before stop", 64'(obs_q.size()), 64'd0);
        end_cmd();
        chk("R4", "busy after stop", 64'(busy), 64'd1);
        wait_idle();
        chk("R4", "requests after stop", 64'(obs_q.size()), 64'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule